// File: doc/BRIEF.md
# Two-Core MESI Coherence Controller

This block keeps two private caches coherent over a shared snooping interconnect and a common backing memory. Each core presents read and write requests by line address. The controller holds a small direct-mapped array per core, and each entry holds a tag, a line of data and a four-state coherence code. For every request the controller looks at both arrays. It decides whether the access can finish locally or needs an interconnect transaction, and it picks the source of the line: backing memory or the other core's cache. It then updates both cores' entries.

Only one transaction is in flight at a time. A core raises its request and holds it until the matching response pulse. It must drop the request before the next rising edge after that pulse. A write carries a byte-enable mask and merges into the line. A read returns the whole line and the state the line holds afterwards in the requesting core. Backing memory answers a fill read one cycle after the read strobe and accepts writebacks in the cycle it is strobed.

Top module: `mesi_pair_ctrl`

## Requirements
- R1: After reset every entry of both cores is Invalid, and no response, interconnect transaction or memory strobe is active. State codes on the response ports are Invalid=0, Shared=1, Exclusive=2, Modified=3.
- R2: A read that misses while the other core holds no copy issues a read transaction (command code 0). It takes the line from memory and leaves it Exclusive in the reader.
- R3: A write to a line held Exclusive completes with no interconnect transaction. It leaves the line Modified with the enabled bytes replaced.
- R4: A read of a line the other core holds Modified is served by that core. The same data is written back to memory in the same cycle, and both copies end Shared.
- R5: A write to a line held Shared issues an invalidate (command code 2) with no memory access. The writer's copy becomes Modified, and the other core's copy becomes Invalid, so its next read misses.
- R6: Coherence state is tracked per line, so writes by the two cores to different bytes of one line take ownership from each other in turn. Every write keeps the bytes it does not enable, which means no byte written by either core is lost.
- R7: A write miss issues a read-for-ownership (command code 1). The line is supplied by the other core, with a writeback, if that core holds it Modified, and from memory otherwise. The other copy becomes Invalid and the writer's copy Modified.
- R8: A read that hits a valid line in any state completes with no interconnect transaction, returning the stored data and unchanged state.
- R9: A read miss while the other core holds the line Exclusive or Shared takes the line from memory without a writeback, and both copies end Shared.
- R10: When both cores request in the same cycle, core 0 is served first. Transactions never overlap, and at most one response is active per cycle.
- R11: A request to a set holding a different line replaces that entry without a writeback, even if the old line was Modified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| c0_req_valid | input | 1 | Core 0 request, held until its response |
| c0_req_write | input | 1 | Core 0 request is a write |
| c0_req_addr | input | 6 | Core 0 line address |
| c0_req_wdata | input | 32 | Core 0 write data |
| c0_req_be | input | 4 | Core 0 byte enables for writes |
| c0_resp_valid | output | 1 | Core 0 response pulse |
| c0_resp_rdata | output | 32 | Line contents after the operation |
| c0_resp_state | output | 2 | Core 0 line state after the operation |
| c1_req_valid | input | 1 | Core 1 request, held until its response |
| c1_req_write | input | 1 | Core 1 request is a write |
| c1_req_addr | input | 6 | Core 1 line address |
| c1_req_wdata | input | 32 | Core 1 write data |
| c1_req_be | input | 4 | Core 1 byte enables for writes |
| c1_resp_valid | output | 1 | Core 1 response pulse |
| c1_resp_rdata | output | 32 | Line contents after the operation |
| c1_resp_state | output | 2 | Core 1 line state after the operation |
| bus_valid | output | 1 | Interconnect transaction this cycle |
| bus_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 invalidate |
| bus_addr | output | 6 | Transaction line address |
| bus_core | output | 1 | Core that initiated the transaction |
| bus_peer_supply | output | 1 | Line supplied by the other core's cache |
| mem_rd_en | output | 1 | Memory fill read strobe |
| mem_wr_en | output | 1 | Memory writeback strobe |
| mem_addr | output | 6 | Memory line address |
| mem_wdata | output | 32 | Writeback data |
| mem_rdata | input | 32 | Fill data, valid one cycle after the read strobe |

## Verification
A wrong state code in either array does not stay hidden for long. The next access to that line from either core shows it, either as a transaction that should not happen (or one that is missing), as a wrong command code, or as a response state or data word that differs from the expected one. A copy left valid after an invalidate shows up on that core's next read as a silent hit with stale data where a supplied or fetched line was due. A lost dirty line shows up on the memory write strobe, or as old data after a later refetch. Every response is compared against a model of the protocol, so a divergence is reported at the first response that depends on it, usually within one or two requests.

// File: rtl/mesi_pkg.sv
// Shared encodings for the two-core coherence controller.
// Assumes the state code values are visible at the ports and must stay fixed.
package mesi_pkg;

    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } mesi_t;

    typedef enum logic [1:0] {
        CMD_RD   = 2'd0,
        CMD_RFO  = 2'd1,
        CMD_INV  = 2'd2,
        CMD_NONE = 2'd3
    } bus_cmd_t;

    typedef enum logic [1:0] {
        FSM_IDLE,
        FSM_LOOKUP,
        FSM_FILL,
        FSM_RESP
    } ctl_t;

endpackage

// File: rtl/mesi_line_store.sv
// Direct-mapped line store for one core: tag, coherence state and data per set.
// Assumes one write per cycle; a state-only write leaves tag and data untouched.
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 4,
    parameter int LINE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [TAG_W-1:0]  rd_tag,
    output mesi_t             rd_st,
    output logic [LINE_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic              wr_line,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  mesi_t             wr_st,
    input  logic [LINE_W-1:0] wr_data
);
    localparam int SETS = 1 << IDX_W;

    logic [TAG_W-1:0]  tag_q  [SETS];
    mesi_t             st_q   [SETS];
    logic [LINE_W-1:0] data_q [SETS];

    // Entry update: reset invalidates all sets, a write updates the addressed set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < SETS; e++) begin
                tag_q[e]  <= '0;
                st_q[e]   <= ST_I;
                data_q[e] <= '0;
            end
        end else if (wr_en) begin
            st_q[wr_idx] <= wr_st;
            if (wr_line) begin
                tag_q[wr_idx]  <= wr_tag;
                data_q[wr_idx] <= wr_data;
            end
        end
    end

    // Asynchronous read of the addressed set.
    always_comb begin
        rd_tag  = tag_q[rd_idx];
        rd_st   = st_q[rd_idx];
        rd_data = data_q[rd_idx];
    end

    for (genvar e = 0; e < SETS; e++) begin : g_rst_chk
        // R1
        rst_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(rst_n) |-> st_q[e] == ST_I);
    end

endmodule

// File: rtl/mesi_arb.sv
// Fixed-priority grant: the lowest-numbered requesting core wins.
// Assumes en is high only while no transaction is in progress.
module mesi_arb #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    // Priority scan from index 0 upward.
    always_comb begin
        logic found;
        found = 1'b0;
        gnt   = '0;
        for (int i = 0; i < N; i++) begin
            if (en && req[i] && !found) begin
                gnt[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    // R10
    arb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));
    // R10
    arb_low_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && req[0]) |-> gnt[0]);

endmodule

// File: rtl/mesi_decide.sv
// Protocol decision for one request, given both cores' view of the line.
// Purely combinational; peer_next only matters when peer_hit is set.
module mesi_decide
    import mesi_pkg::*;
(
    input  logic     is_write,
    input  logic     own_hit,
    input  mesi_t    own_st,
    input  logic     peer_hit,
    input  mesi_t    peer_st,
    output logic     bus_en,
    output bus_cmd_t cmd,
    output logic     need_mem,
    output logic     peer_supply,
    output logic     peer_wb,
    output mesi_t    own_next,
    output mesi_t    peer_next
);
    // Select transaction, data source and next states.
    always_comb begin
        bus_en      = 1'b0;
        cmd         = CMD_NONE;
        need_mem    = 1'b0;
        peer_supply = 1'b0;
        peer_wb     = 1'b0;
        own_next    = own_st;
        peer_next   = peer_st;
        if (!is_write) begin
            if (!own_hit) begin
                bus_en = 1'b1;
                cmd    = CMD_RD;
                if (peer_hit && peer_st == ST_M) begin
                    peer_supply = 1'b1;
                    peer_wb     = 1'b1;
                    own_next    = ST_S;
                    peer_next   = ST_S;
                end else if (peer_hit) begin
                    need_mem  = 1'b1;
                    own_next  = ST_S;
                    peer_next = ST_S;
                end else begin
                    need_mem = 1'b1;
                    own_next = ST_E;
                end
            end
        end else begin
            own_next = ST_M;
            if (own_hit && own_st == ST_S) begin
                bus_en = 1'b1;
                cmd    = CMD_INV;
                if (peer_hit) peer_next = ST_I;
            end else if (!own_hit) begin
                bus_en = 1'b1;
                cmd    = CMD_RFO;
                if (peer_hit) peer_next = ST_I;
                if (peer_hit && peer_st == ST_M) begin
                    peer_supply = 1'b1;
                    peer_wb     = 1'b1;
                end else begin
                    need_mem = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/mesi_pair_ctrl.sv
// Coherence controller for two private caches on one snooping interconnect.
// Serves one request at a time: grant, lookup of both stores, optional memory
// fill, response. Assumes a requester holds its request until its response
// pulse and drops it before the following edge; memory data follows the read
// strobe by one cycle.
module mesi_pair_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int IDX_W  = 2,
    parameter int LINE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              c0_req_valid,
    input  logic              c0_req_write,
    input  logic [ADDR_W-1:0] c0_req_addr,
    input  logic [LINE_W-1:0] c0_req_wdata,
    input  logic [LINE_W/8-1:0] c0_req_be,
    output logic              c0_resp_valid,
    output logic [LINE_W-1:0] c0_resp_rdata,
    output logic [1:0]        c0_resp_state,
    input  logic              c1_req_valid,
    input  logic              c1_req_write,
    input  logic [ADDR_W-1:0] c1_req_addr,
    input  logic [LINE_W-1:0] c1_req_wdata,
    input  logic [LINE_W/8-1:0] c1_req_be,
    output logic              c1_resp_valid,
    output logic [LINE_W-1:0] c1_resp_rdata,
    output logic [1:0]        c1_resp_state,
    output logic              bus_valid,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_core,
    output logic              bus_peer_supply,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_wdata,
    input  logic [LINE_W-1:0] mem_rdata
);
    localparam int TAG_W = ADDR_W - IDX_W;
    localparam int BE_W  = LINE_W / 8;
    localparam int NCORE = 2;

    ctl_t              fsm_q;
    logic              cur_core_q;
    logic              cur_wr_q;
    logic [ADDR_W-1:0] cur_addr_q;
    logic [LINE_W-1:0] cur_wdata_q;
    logic [BE_W-1:0]   cur_be_q;
    mesi_t             own_next_q;
    logic [LINE_W-1:0] resp_data_q;
    mesi_t             resp_st_q;

    logic [NCORE-1:0]  gnt;
    logic [IDX_W-1:0]  cur_idx;
    logic [TAG_W-1:0]  cur_tag;
    logic              own;
    logic              peer;

    logic [TAG_W-1:0]  rd_tag  [NCORE];
    mesi_t             rd_st   [NCORE];
    logic [LINE_W-1:0] rd_data [NCORE];
    logic              wr_en   [NCORE];
    logic              wr_line [NCORE];
    mesi_t             wr_st   [NCORE];

    logic              own_hit;
    logic              peer_hit;
    logic              dec_bus_en;
    bus_cmd_t          dec_cmd;
    logic              dec_need_mem;
    logic              dec_supply;
    logic              dec_wb;
    mesi_t             dec_own_next;
    mesi_t             dec_peer_next;

    logic [LINE_W-1:0] base_line;
    logic [LINE_W-1:0] merged;

    assign cur_idx = cur_addr_q[IDX_W-1:0];
    assign cur_tag = cur_addr_q[ADDR_W-1:IDX_W];
    assign own     = cur_core_q;
    assign peer    = ~cur_core_q;

    mesi_arb #(.N(NCORE)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (fsm_q == FSM_IDLE),
        .req   ({c1_req_valid, c0_req_valid}),
        .gnt   (gnt)
    );

    for (genvar c = 0; c < NCORE; c++) begin : g_store
        mesi_line_store #(
            .IDX_W  (IDX_W),
            .TAG_W  (TAG_W),
            .LINE_W (LINE_W)
        ) u_store (
            .clk     (clk),
            .rst_n   (rst_n),
            .rd_idx  (cur_idx),
            .rd_tag  (rd_tag[c]),
            .rd_st   (rd_st[c]),
            .rd_data (rd_data[c]),
            .wr_en   (wr_en[c]),
            .wr_line (wr_line[c]),
            .wr_idx  (cur_idx),
            .wr_tag  (cur_tag),
            .wr_st   (wr_st[c]),
            .wr_data (merged)
        );
    end

    // Hit detection in the requester's and the other core's store.
    always_comb begin
        own_hit  = (rd_st[own] != ST_I) && (rd_tag[own] == cur_tag);
        peer_hit = (rd_st[peer] != ST_I) && (rd_tag[peer] == cur_tag);
    end

    mesi_decide u_decide (
        .is_write    (cur_wr_q),
        .own_hit     (own_hit),
        .own_st      (rd_st[own]),
        .peer_hit    (peer_hit),
        .peer_st     (rd_st[peer]),
        .bus_en      (dec_bus_en),
        .cmd         (dec_cmd),
        .need_mem    (dec_need_mem),
        .peer_supply (dec_supply),
        .peer_wb     (dec_wb),
        .own_next    (dec_own_next),
        .peer_next   (dec_peer_next)
    );

    // Line source before the write merge: memory fill, own copy or peer copy.
    always_comb begin
        if (fsm_q == FSM_FILL)
            base_line = mem_rdata;
        else if (own_hit)
            base_line = rd_data[own];
        else
            base_line = rd_data[peer];
    end

    for (genvar b = 0; b < BE_W; b++) begin : g_merge
        assign merged[b*8 +: 8] = cur_be_q[b] ? cur_wdata_q[b*8 +: 8] : base_line[b*8 +: 8];
    end

    // Store write controls: peer state change at lookup, own install at lookup or fill.
    always_comb begin
        for (int c = 0; c < NCORE; c++) begin
            wr_en[c]   = 1'b0;
            wr_line[c] = 1'b0;
            wr_st[c]   = ST_I;
        end
        if (fsm_q == FSM_LOOKUP) begin
            if (peer_hit) begin
                wr_en[peer] = 1'b1;
                wr_st[peer] = dec_peer_next;
            end
            if (!dec_need_mem) begin
                wr_en[own]   = 1'b1;
                wr_line[own] = 1'b1;
                wr_st[own]   = dec_own_next;
            end
        end else if (fsm_q == FSM_FILL) begin
            wr_en[own]   = 1'b1;
            wr_line[own] = 1'b1;
            wr_st[own]   = own_next_q;
        end
    end

    // Transaction sequencer: latch a granted request, resolve it, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q       <= FSM_IDLE;
            cur_core_q  <= 1'b0;
            cur_wr_q    <= 1'b0;
            cur_addr_q  <= '0;
            cur_wdata_q <= '0;
            cur_be_q    <= '0;
            own_next_q  <= ST_I;
            resp_data_q <= '0;
            resp_st_q   <= ST_I;
        end else begin
            unique case (fsm_q)
                FSM_IDLE: begin
                    if (|gnt) begin
                        cur_core_q  <= gnt[1];
                        cur_wr_q    <= gnt[1] ? c1_req_write : c0_req_write;
                        cur_addr_q  <= gnt[1] ? c1_req_addr : c0_req_addr;
                        cur_wdata_q <= gnt[1] ? c1_req_wdata : c0_req_wdata;
                        if (gnt[1])
                            cur_be_q <= c1_req_write ? c1_req_be : '0;
                        else
                            cur_be_q <= c0_req_write ? c0_req_be : '0;
                        fsm_q <= FSM_LOOKUP;
                    end
                end
                FSM_LOOKUP: begin
                    own_next_q <= dec_own_next;
                    if (dec_need_mem) begin
                        fsm_q <= FSM_FILL;
                    end else begin
                        resp_data_q <= merged;
                        resp_st_q   <= dec_own_next;
                        fsm_q       <= FSM_RESP;
                    end
                end
                FSM_FILL: begin
                    resp_data_q <= merged;
                    resp_st_q   <= own_next_q;
                    fsm_q       <= FSM_RESP;
                end
                default: fsm_q <= FSM_IDLE;
            endcase
        end
    end

    // Port outputs: response, interconnect and memory signalling.
    always_comb begin
        c0_resp_valid   = (fsm_q == FSM_RESP) && !cur_core_q;
        c1_resp_valid   = (fsm_q == FSM_RESP) && cur_core_q;
        c0_resp_rdata   = resp_data_q;
        c1_resp_rdata   = resp_data_q;
        c0_resp_state   = resp_st_q;
        c1_resp_state   = resp_st_q;
        bus_valid       = (fsm_q == FSM_LOOKUP) && dec_bus_en;
        bus_cmd         = dec_cmd;
        bus_addr        = cur_addr_q;
        bus_core        = cur_core_q;
        bus_peer_supply = (fsm_q == FSM_LOOKUP) && dec_supply;
        mem_rd_en       = (fsm_q == FSM_LOOKUP) && dec_need_mem;
        mem_wr_en       = (fsm_q == FSM_LOOKUP) && dec_wb;
        mem_addr        = cur_addr_q;
        mem_wdata       = rd_data[peer];
    end

    // R4
    wb_with_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (bus_valid && bus_peer_supply));
    // R5
    inv_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_cmd == CMD_INV) |-> (!mem_rd_en && !mem_wr_en));
    // R7
    owner_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q == FSM_LOOKUP && dec_own_next == ST_M && peer_hit) |-> dec_peer_next == ST_I);
    // R9
    one_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !bus_peer_supply);
    // R10
    resp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({c1_resp_valid, c0_resp_valid}));
    // R8
    local_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q == FSM_LOOKUP && !cur_wr_q && own_hit) |-> (!bus_valid && !mem_rd_en));

endmodule

// File: tb/tb_mesi_pair_ctrl.sv
`timescale 1ns/1ps
module tb_mesi_pair_ctrl;
    localparam int AW   = 6;
    localparam int IW   = 2;
    localparam int LW   = 32;
    localparam int BW   = 4;
    localparam int SETS = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n;
    logic          c0_req_valid, c0_req_write;
    logic [AW-1:0] c0_req_addr;
    logic [LW-1:0] c0_req_wdata;
    logic [BW-1:0] c0_req_be;
    logic          c0_resp_valid;
    logic [LW-1:0] c0_resp_rdata;
    logic [1:0]    c0_resp_state;
    logic          c1_req_valid, c1_req_write;
    logic [AW-1:0] c1_req_addr;
    logic [LW-1:0] c1_req_wdata;
    logic [BW-1:0] c1_req_be;
    logic          c1_resp_valid;
    logic [LW-1:0] c1_resp_rdata;
    logic [1:0]    c1_resp_state;
    logic          bus_valid;
    logic [1:0]    bus_cmd;
    logic [AW-1:0] bus_addr;
    logic          bus_core;
    logic          bus_peer_supply;
    logic          mem_rd_en, mem_wr_en;
    logic [AW-1:0] mem_addr;
    logic [LW-1:0] mem_wdata;
    logic [LW-1:0] mem_rdata;

    mesi_pair_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .c0_req_valid(c0_req_valid), .c0_req_write(c0_req_write), .c0_req_addr(c0_req_addr),
        .c0_req_wdata(c0_req_wdata), .c0_req_be(c0_req_be), .c0_resp_valid(c0_resp_valid),
        .c0_resp_rdata(c0_resp_rdata), .c0_resp_state(c0_resp_state),
        .c1_req_valid(c1_req_valid), .c1_req_write(c1_req_write), .c1_req_addr(c1_req_addr),
        .c1_req_wdata(c1_req_wdata), .c1_req_be(c1_req_be), .c1_resp_valid(c1_resp_valid),
        .c1_resp_rdata(c1_resp_rdata), .c1_resp_state(c1_resp_state),
        .bus_valid(bus_valid), .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_core(bus_core),
        .bus_peer_supply(bus_peer_supply), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Backing memory: one-cycle fill latency, writeback on the strobe edge.
    logic [LW-1:0] env_mem [64];
    always @(posedge clk) begin
        if (mem_wr_en) env_mem[mem_addr] <= mem_wdata;
        if (mem_rd_en) mem_rdata <= env_mem[mem_addr];
    end

    // Protocol model (codes: state I0 S1 E2 M3; cmd 0 none, 1 rd, 2 rfo, 3 inv).
    logic [LW-1:0]    ref_mem [64];
    logic [AW-IW-1:0] m_tag [2][SETS];
    int               m_st  [2][SETS];
    logic [LW-1:0]    m_dat [2][SETS];

    typedef struct {
        int          core;
        int          st;
        logic [31:0] dat;
        int          cmd;
        bit          wb;
        logic [31:0] wbd;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    function automatic logic [31:0] merge_be(logic [31:0] base, logic [31:0] d, logic [3:0] be);
        logic [31:0] r;
        r = base;
        for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = d[b*8 +: 8];
        return r;
    endfunction

    function automatic exp_t predict(int c, bit w, logic [AW-1:0] a, logic [31:0] d,
                                     logic [3:0] be, string tg);
        exp_t e;
        int p, ix;
        bit oh, ph;
        logic [31:0] base;
        p  = 1 - c;
        ix = int'(a[IW-1:0]);
        oh = (m_st[c][ix] != 0) && (m_tag[c][ix] == a[AW-1:IW]);
        ph = (m_st[p][ix] != 0) && (m_tag[p][ix] == a[AW-1:IW]);
        e.core = c; e.cmd = 0; e.wb = 1'b0; e.wbd = '0; e.tag = tg;
        if (oh) base = m_dat[c][ix];
        else if (ph && m_st[p][ix] == 3) base = m_dat[p][ix];
        else base = ref_mem[a];
        if (!oh && ph && m_st[p][ix] == 3) begin
            e.wb = 1'b1; e.wbd = m_dat[p][ix]; ref_mem[a] = m_dat[p][ix];
        end
        if (!w) begin
            if (oh) begin
                e.st = m_st[c][ix];
            end else begin
                e.cmd = 1;
                if (ph) begin e.st = 1; m_st[p][ix] = 1; end
                else e.st = 2;
            end
            e.dat = base;
        end else begin
            if (oh && m_st[c][ix] == 1) e.cmd = 3;
            else if (!oh) e.cmd = 2;
            if (e.cmd != 0 && ph) m_st[p][ix] = 0;
            e.st  = 3;
            e.dat = merge_be(base, d, be);
        end
        m_tag[c][ix] = a[AW-1:IW];
        m_st[c][ix]  = e.st;
        m_dat[c][ix] = e.dat;
        return e;
    endfunction

    // Monitor: collect transaction evidence, compare at each response.
    int          seen_cmd = 0;
    bit          seen_wb  = 1'b0;
    logic [31:0] seen_wbd = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (bus_valid) seen_cmd = int'(bus_cmd) + 1;
            if (mem_wr_en) begin seen_wb = 1'b1; seen_wbd = mem_wdata; end
            if (c0_resp_valid || c1_resp_valid) begin
                int gc, gs;
                logic [31:0] gd;
                gc = c1_resp_valid ? 1 : 0;
                gs = c1_resp_valid ? int'(c1_resp_state) : int'(c0_resp_state);
                gd = c1_resp_valid ? c1_resp_rdata : c0_resp_rdata;
                n_cmp++;
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R10 unexpected response core %0d, expected none", gc);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (gc != e.core || gs != e.st || gd != e.dat || seen_cmd != e.cmd ||
                        seen_wb != e.wb || (e.wb && seen_wbd != e.wbd)) begin
                        n_bad++;
                        $display("FAIL %s actual core=%0d st=%0d dat=%h cmd=%0d wb=%0d wbd=%h expected core=%0d st=%0d dat=%h cmd=%0d wb=%0d wbd=%h",
                                 e.tag, gc, gs, gd, seen_cmd, seen_wb, seen_wbd,
                                 e.core, e.st, e.dat, e.cmd, e.wb, e.wbd);
                    end
                end
                seen_cmd = 0;
                seen_wb  = 1'b0;
            end
        end
    end

    task automatic drive(int c, bit v, bit w, logic [AW-1:0] a, logic [31:0] d, logic [3:0] be);
        if (c == 0) begin
            c0_req_valid = v; c0_req_write = w; c0_req_addr = a; c0_req_wdata = d; c0_req_be = be;
        end else begin
            c1_req_valid = v; c1_req_write = w; c1_req_addr = a; c1_req_wdata = d; c1_req_be = be;
        end
    endtask

    task automatic wait_resp(int c);
        do @(negedge clk); while (!((c == 0) ? c0_resp_valid : c1_resp_valid));
    endtask

    // Driver: predict, push, issue and wait for one request.
    task automatic issue(int c, bit w, logic [AW-1:0] a, logic [31:0] d, logic [3:0] be, string tg);
        exp_q.push_back(predict(c, w, a, d, be, tg));
        drive(c, 1'b1, w, a, d, be);
        wait_resp(c);
        drive(c, 1'b0, 1'b0, '0, '0, '0);
    endtask

    // Driver: both cores raise requests in the same cycle; core 0 is expected first.
    task automatic issue_pair(bit w0, logic [AW-1:0] a0, logic [31:0] d0, logic [3:0] b0,
                              bit w1, logic [AW-1:0] a1, logic [31:0] d1, logic [3:0] b1, string tg);
        exp_q.push_back(predict(0, w0, a0, d0, b0, tg));
        exp_q.push_back(predict(1, w1, a1, d1, b1, tg));
        drive(0, 1'b1, w0, a0, d0, b0);
        drive(1, 1'b1, w1, a1, d1, b1);
        wait_resp(0);
        drive(0, 1'b0, 1'b0, '0, '0, '0);
        wait_resp(1);
        drive(1, 1'b0, 1'b0, '0, '0, '0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 50000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired, actual cycles=%0d expected below 50000", cyc);
            finish_run();
        end
    end

    localparam logic [AW-1:0] LA = 6'h05;  // set 1
    localparam logic [AW-1:0] LB = 6'h0A;  // set 2
    localparam logic [AW-1:0] LC = 6'h03;  // set 3
    localparam logic [AW-1:0] LD = 6'h00;  // set 0, tag 0
    localparam logic [AW-1:0] LE = 6'h04;  // set 0, tag 1: conflicts with LD

    initial begin
        for (int a = 0; a < 64; a++) begin
            env_mem[a] = 32'hC0DE_0000 + 32'(a * 257);
            ref_mem[a] = 32'hC0DE_0000 + 32'(a * 257);
        end
        for (int c = 0; c < 2; c++)
            for (int s = 0; s < SETS; s++) begin
                m_tag[c][s] = '0; m_st[c][s] = 0; m_dat[c][s] = '0;
            end
        mem_rdata = '0;
        rst_n = 1'b0;
        drive(0, 1'b0, 1'b0, '0, '0, '0);
        drive(1, 1'b0, 1'b0, '0, '0, '0);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: quiet ports after reset
        n_cmp++;
        if (c0_resp_valid || c1_resp_valid || bus_valid || mem_rd_en || mem_wr_en) begin
            n_bad++;
            $display("FAIL R1 actual resp=%b%b bus=%b rd=%b wr=%b expected all 0",
                     c0_resp_valid, c1_resp_valid, bus_valid, mem_rd_en, mem_wr_en);
        end
        issue(0, 0, LA, '0, 4'h0, "R2 read miss installs Exclusive");
        issue(0, 1, LA, 32'h0000_0011, 4'h1, "R3 silent upgrade");
        issue(0, 0, LA, '0, 4'h0, "R8 read hit Modified");
        issue(1, 0, LA, '0, 4'h0, "R4 dirty supply with writeback");
        issue(0, 0, LA, '0, 4'h0, "R8 read hit Shared after R4");
        issue(1, 1, LA, 32'h0022_0000, 4'h4, "R5 invalidate on Shared write");
        issue(0, 0, LA, '0, 4'h0, "R5 invalidated copy misses");
        issue(0, 1, LA, 32'h0000_0033, 4'h1, "R6 false sharing core0");
        issue(1, 1, LA, 32'h0044_0000, 4'h4, "R6 false sharing core1");
        issue(0, 1, LA, 32'h0000_0055, 4'h1, "R6 false sharing core0 again");
        issue(1, 0, LA, '0, 4'h0, "R6 merged bytes survive");
        issue(1, 0, LB, '0, 4'h0, "R2 second line Exclusive");
        issue(0, 1, LB, 32'hABCD_0000, 4'hC, "R7 write miss over clean copy");
        issue(1, 0, LB, '0, 4'h0, "R4 owner supplies after R7");
        issue(0, 0, LC, '0, 4'h0, "R2 third line");
        issue(1, 0, LC, '0, 4'h0, "R9 read of Exclusive copy");
        issue(0, 0, LC, '0, 4'h0, "R9 both copies Shared");
        issue(1, 1, LD, 32'h7777_7777, 4'hF, "R7 write miss from memory");
        issue(1, 0, LE, '0, 4'h0, "R11 conflicting line replaces Modified");
        issue(1, 0, LD, '0, 4'h0, "R11 dropped line refetched");
        issue_pair(0, LC, '0, 4'h0, 1, LC, 32'h0000_9900, 4'h2, "R10 same-cycle requests");
        issue_pair(1, LB, 32'h0000_0066, 4'h1, 1, LB, 32'h8800_0000, 4'h8, "R10 same-cycle writes");
        issue(0, 0, LB, '0, 4'h0, "R10 final line after pair");
        repeat (4) @(negedge clk);
        // R10: every expected response arrived
        n_cmp++;
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R10 actual pending=%0d expected 0", exp_q.size());
        end
        finish_run();
    end

endmodule